// File: doc/BRIEF.md
# Multicore Launch and Run-State Controller

This block sits on a register bus shared by a small cluster of processor cores and decides which of them may run. It keeps one common entry address and one common initial stack value. Software on any core writes a core number to a command register to launch that core with those two values, to stop every core but one, or to release a single core. Read-only registers report the identity of the requesting core, how many cores the cluster has, and how many bytes of memory are installed.

The bus port takes one access per clock with a request strobe, a write flag, a size flag (narrow 32-bit or wide 64-bit), a 4-bit register offset, write data and the requester's core number. Read data and an error flag come back registered, in the cycle after the request. Toward the cores the block drives one run-enable bit per core, one-cycle load strobes for the program counter and stack pointer, and the two values to be loaded.

Top module: `core_launch_ctrl`

## Requirements
- R1: After reset only core 0 has run-enable set, the entry and stack registers hold their parameter defaults, and no load strobe or error is active.
- R2: A read of offset 0x0 returns the requester's core number, zero-extended, in the cycle after the request.
- R3: A read of offset 0x1 returns the NUM_CORES parameter; a read of offset 0x7 returns MEM_MB times 1048576.
- R4: Writing core index k (low 16 bits of write data) to offset 0x2 with k < NUM_CORES raises the PC and SP load strobes of core k alone for exactly the next cycle, sets its run-enable, and presents the stored entry and stack values; k out of range changes nothing.
- R5: A narrow write (size flag 0) to offset 0x3 (entry) or 0x4 (stack) keeps only data bits 31:0, and when bit 31 is set fills bits 63:32 with ones; a wide write stores all 64 bits unchanged.
- R6: Writing index k to offset 0x5 clears run-enable of every core other than k and leaves core k as it was; an out-of-range k clears all cores.
- R7: Writing index k to offset 0x6 sets run-enable of core k when k < NUM_CORES and has no effect otherwise.
- R8: An access to offsets 0x8 to 0xF returns zero and raises the error flag for exactly the one response cycle; reads of command offsets (0x2 to 0x6) return zero without error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access strobe |
| req_write | input | 1 | 1 write, 0 read |
| req_wide | input | 1 | 1 for a 64-bit access, 0 for 32-bit |
| req_off | input | 4 | Register offset |
| req_wdata | input | 64 | Write data |
| req_src | input | ID_W | Core number of the requester |
| rsp_rdata | output | 64 | Read data, one cycle after the request |
| rsp_err | output | 1 | Unimplemented-offset flag, one cycle after the request |
| core_run | output | NUM_CORES | Run-enable per core |
| core_pc_load | output | NUM_CORES | Program-counter load strobe per core |
| core_sp_load | output | NUM_CORES | Stack-pointer load strobe per core |
| core_pc_val | output | 64 | Entry address to load |
| core_sp_val | output | 64 | Initial stack value to load |

## Verification
Narrow writes are tried with bit 31 set and clear, and a wide write with bit 31 set, which separates sign extension from plain truncation and from extending wide data. Run-state commands are applied from several starting masks: halting with the kept core running and with it stopped shows that its bit is untouched rather than forced, and in-range versus out-of-range indices show the range check on launch and release and its absence on halt. Reads from two different requesters tell the identity register from a constant.

// File: rtl/core_launch_pkg.sv
package core_launch_pkg;
  localparam int OFF_W  = 4;
  localparam int DATA_W = 64;
  localparam int IDX_W  = 16;

  typedef enum logic [OFF_W-1:0] {
    OFF_WHOAMI = 4'h0,
    OFF_COUNT  = 4'h1,
    OFF_LAUNCH = 4'h2,
    OFF_ENTRY  = 4'h3,
    OFF_STACK  = 4'h4,
    OFF_HALT   = 4'h5,
    OFF_RESUME = 4'h6,
    OFF_MEMSZ  = 4'h7
  } reg_off_e;

  typedef struct packed {
    logic launch;
    logic entry;
    logic stack;
    logic halt;
    logic resume;
  } wr_cmd_t;
endpackage

// File: rtl/cl_addr_regs.sv
module cl_addr_regs
  import core_launch_pkg::*;
#(
  parameter logic [DATA_W-1:0] ENTRY_RST = 64'h0000_0000_8000_0000,
  parameter logic [DATA_W-1:0] STACK_RST = 64'h0000_0000_0010_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_entry,
  input  logic              wr_stack,
  input  logic              wide,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] entry_q,
  output logic [DATA_W-1:0] stack_q
);
  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] shaped;
  logic [DATA_W-1:0] entry_d, stack_d;

  always_comb begin
    if (wide) begin
      shaped = wdata;
    end else begin
      shaped = {{HALF_W{wdata[HALF_W-1]}}, wdata[HALF_W-1:0]};
    end
  end

  always_comb begin
    entry_d = entry_q;
    stack_d = stack_q;
    if (wr_entry) entry_d = shaped;
    if (wr_stack) stack_d = shaped;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      entry_q <= ENTRY_RST;
      stack_q <= STACK_RST;
    end else begin
      entry_q <= entry_d;
      stack_q <= stack_d;
    end
  end

  p_narrow_ext_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_entry && !wide) |=> (entry_q[HALF_W-1:0] == $past(wdata[HALF_W-1:0]))
      && (entry_q[DATA_W-1:HALF_W] == {HALF_W{$past(wdata[HALF_W-1])}}));
  p_wide_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stack && wide) |=> (stack_q == $past(wdata)));
endmodule

// File: rtl/cl_run_ctrl.sv
module cl_run_ctrl
  import core_launch_pkg::*;
#(
  parameter int NUM_CORES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 do_launch,
  input  logic                 do_halt,
  input  logic                 do_resume,
  input  logic [IDX_W-1:0]     idx,
  output logic [NUM_CORES-1:0] run_q,
  output logic [NUM_CORES-1:0] pc_ld_q,
  output logic [NUM_CORES-1:0] sp_ld_q
);
  logic                 in_range;
  logic [NUM_CORES-1:0] run_d;
  logic [NUM_CORES-1:0] ld_d;

  assign in_range = (32'(idx) < NUM_CORES);

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    logic hit;
    assign hit = (32'(idx) == c);

    always_comb begin
      run_d[c] = run_q[c];
      ld_d[c]  = 1'b0;
      if (do_launch && hit) begin
        run_d[c] = 1'b1;
        ld_d[c]  = 1'b1;
      end
      if (do_halt && !hit)             run_d[c] = 1'b0;
      if (do_resume && hit && in_range) run_d[c] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        run_q[c]   <= (c == 0);
        pc_ld_q[c] <= 1'b0;
        sp_ld_q[c] <= 1'b0;
      end else begin
        run_q[c]   <= run_d[c];
        pc_ld_q[c] <= ld_d[c];
        sp_ld_q[c] <= ld_d[c];
      end
    end
  end

  p_ld_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pc_ld_q));
  p_ld_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|pc_ld_q) |-> $past(do_launch && in_range));
  p_launch_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (do_launch && in_range) |=> (run_q[$past(idx)] && pc_ld_q[$past(idx)]));
  p_halt_rest_r6: assert property (@(posedge clk) disable iff (!rst_n)
    do_halt |=> ($countones(run_q) <= 1));
  p_resume_oor_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (do_resume && !in_range) |=> $stable(run_q));
endmodule

// File: rtl/cl_read_path.sv
module cl_read_path
  import core_launch_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int MEM_MB    = 32,
  parameter int ID_W      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid,
  input  logic              write,
  input  logic [OFF_W-1:0]  off,
  input  logic [ID_W-1:0]   src,
  output logic [DATA_W-1:0] rdata_q,
  output logic              err_q
);
  localparam logic [DATA_W-1:0] MEM_BYTES = DATA_W'(MEM_MB) << 20;
  localparam logic [DATA_W-1:0] CORE_CNT  = DATA_W'(NUM_CORES);

  logic [DATA_W-1:0] rdata_d;
  logic              err_d;
  logic              known;

  always_comb begin
    rdata_d = '0;
    known   = 1'b1;
    unique case (off)
      OFF_WHOAMI: rdata_d = DATA_W'(src);
      OFF_COUNT:  rdata_d = CORE_CNT;
      OFF_MEMSZ:  rdata_d = MEM_BYTES;
      OFF_LAUNCH, OFF_ENTRY, OFF_STACK, OFF_HALT, OFF_RESUME: rdata_d = '0;
      default:    known = 1'b0;
    endcase
    if (!valid || write) rdata_d = '0;
    err_d = valid && !known;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      rdata_q <= rdata_d;
      err_q   <= err_d;
    end
  end

  p_err_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> ($past(valid) && $past(off[OFF_W-1])));
  p_err_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> (rdata_q == '0));
endmodule

// File: rtl/core_launch_ctrl.sv
module core_launch_ctrl
  import core_launch_pkg::*;
#(
  parameter int                NUM_CORES = 4,
  parameter int                MEM_MB    = 32,
  parameter logic [63:0]       ENTRY_RST = 64'h0000_0000_8000_0000,
  parameter logic [63:0]       STACK_RST = 64'h0000_0000_0010_0000,
  parameter int                ID_W      = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic                 req_wide,
  input  logic [3:0]           req_off,
  input  logic [63:0]          req_wdata,
  input  logic [ID_W-1:0]      req_src,
  output logic [63:0]          rsp_rdata,
  output logic                 rsp_err,
  output logic [NUM_CORES-1:0] core_run,
  output logic [NUM_CORES-1:0] core_pc_load,
  output logic [NUM_CORES-1:0] core_sp_load,
  output logic [63:0]          core_pc_val,
  output logic [63:0]          core_sp_val
);
  logic [1:0] rst_sync;
  logic       rst_int_n;
  wr_cmd_t    cmd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  always_comb begin
    cmd        = '0;
    if (req_valid && req_write) begin
      cmd.launch = (req_off == OFF_LAUNCH);
      cmd.entry  = (req_off == OFF_ENTRY);
      cmd.stack  = (req_off == OFF_STACK);
      cmd.halt   = (req_off == OFF_HALT);
      cmd.resume = (req_off == OFF_RESUME);
    end
  end

  cl_addr_regs #(
    .ENTRY_RST(ENTRY_RST),
    .STACK_RST(STACK_RST)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_entry(cmd.entry),
    .wr_stack(cmd.stack),
    .wide    (req_wide),
    .wdata   (req_wdata),
    .entry_q (core_pc_val),
    .stack_q (core_sp_val)
  );

  cl_run_ctrl #(
    .NUM_CORES(NUM_CORES)
  ) u_run (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .do_launch(cmd.launch),
    .do_halt  (cmd.halt),
    .do_resume(cmd.resume),
    .idx      (req_wdata[IDX_W-1:0]),
    .run_q    (core_run),
    .pc_ld_q  (core_pc_load),
    .sp_ld_q  (core_sp_load)
  );

  cl_read_path #(
    .NUM_CORES(NUM_CORES),
    .MEM_MB   (MEM_MB),
    .ID_W     (ID_W)
  ) u_rd (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .valid  (req_valid),
    .write  (req_write),
    .off    (req_off),
    .src    (req_src),
    .rdata_q(rsp_rdata),
    .err_q  (rsp_err)
  );

  p_strobe_pair_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    core_pc_load == core_sp_load);
  p_whoami_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    (req_valid && !req_write && req_off == OFF_WHOAMI)
      |=> (rsp_rdata == 64'($past(req_src))));
endmodule

// File: tb/core_launch_ctrl_bench.sv
module core_launch_ctrl_bench;
  localparam int PERIOD = 10;
  localparam int NC     = 4;
  localparam logic [63:0] ENTRY0 = 64'h0000_0000_8000_0000;
  localparam logic [63:0] STACK0 = 64'h0000_0000_0010_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_wide = 1'b0;
  logic [3:0]  req_off = '0;
  logic [63:0] req_wdata = '0;
  logic [1:0]  req_src = '0;
  logic [63:0] rsp_rdata, core_pc_val, core_sp_val;
  logic        rsp_err;
  logic [NC-1:0] core_run, core_pc_load, core_sp_load;

  int checks = 0;
  int failures = 0;

  always #(PERIOD/2) clk = ~clk;

  core_launch_ctrl #(.NUM_CORES(NC), .MEM_MB(32), .ENTRY_RST(ENTRY0), .STACK_RST(STACK0))
  u_core_launch_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_wide(req_wide), .req_off(req_off), .req_wdata(req_wdata), .req_src(req_src),
    .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .core_run(core_run),
    .core_pc_load(core_pc_load), .core_sp_load(core_sp_load),
    .core_pc_val(core_pc_val), .core_sp_val(core_sp_val)
  );

  typedef struct packed {
    logic [3:0]  off;
    logic [1:0]  src;
    logic [63:0] rdata;
    logic        err;
  } rd_vec_t;

  localparam rd_vec_t RD_TABLE [8] = '{
    '{4'h0, 2'd2, 64'd2,          1'b0},  // R2
    '{4'h0, 2'd3, 64'd3,          1'b0},  // R2
    '{4'h1, 2'd0, 64'd4,          1'b0},  // R3
    '{4'h7, 2'd1, 64'h200_0000,   1'b0},  // R3
    '{4'h2, 2'd0, 64'd0,          1'b0},  // R8
    '{4'h4, 2'd0, 64'd0,          1'b0},  // R8
    '{4'h8, 2'd0, 64'd0,          1'b1},  // R8
    '{4'hF, 2'd1, 64'd0,          1'b1}   // R8
  };

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive one access at a falling edge; sample its results at the next falling edge.
  task automatic access(input bit wr, input bit wide, input logic [3:0] off,
                        input logic [63:0] data, input logic [1:0] src);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_wide = wide;
    req_off = off; req_wdata = data; req_src = src;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  initial begin
    #(PERIOD * 100000);
    failures++;
    $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk(core_run == 4'b0001, "R1 run", 64'(core_run), 64'h1);
    chk(core_pc_val == ENTRY0, "R1 entry", core_pc_val, ENTRY0);
    chk(core_sp_val == STACK0, "R1 stack", core_sp_val, STACK0);
    chk(core_pc_load == 0 && core_sp_load == 0, "R1 strobes", 64'(core_pc_load), 64'h0);
    chk(rsp_err == 1'b0, "R1 err", 64'(rsp_err), 64'h0);

    // Table of reads (R2, R3, R8)
    foreach (RD_TABLE[i]) begin
      access(1'b0, 1'b1, RD_TABLE[i].off, 64'd0, RD_TABLE[i].src);
      chk(rsp_rdata == RD_TABLE[i].rdata, $sformatf("R2/R3/R8 vec%0d rdata", i),
          rsp_rdata, RD_TABLE[i].rdata);
      chk(rsp_err == RD_TABLE[i].err, $sformatf("R8 vec%0d err", i),
          64'(rsp_err), 64'(RD_TABLE[i].err));
    end
    idle();
    chk(rsp_err == 1'b0, "R8 err one cycle", 64'(rsp_err), 64'h0);
    access(1'b1, 1'b1, 4'hA, 64'd5, 2'd0);
    chk(rsp_err == 1'b1, "R8 write err", 64'(rsp_err), 64'h1);

    // R5 sign extension
    access(1'b1, 1'b0, 4'h3, 64'h0000_0000_8000_1234, 2'd0);
    chk(core_pc_val == 64'hFFFF_FFFF_8000_1234, "R5 narrow neg", core_pc_val, 64'hFFFF_FFFF_8000_1234);
    access(1'b1, 1'b0, 4'h3, 64'hDEAD_0000_0000_1234, 2'd0);
    chk(core_pc_val == 64'h0000_0000_0000_1234, "R5 narrow pos", core_pc_val, 64'h1234);
    access(1'b1, 1'b1, 4'h3, 64'h0000_0000_9000_0000, 2'd0);
    chk(core_pc_val == 64'h0000_0000_9000_0000, "R5 wide", core_pc_val, 64'h9000_0000);
    access(1'b1, 1'b0, 4'h4, 64'h0000_0000_C000_0000, 2'd0);
    chk(core_sp_val == 64'hFFFF_FFFF_C000_0000, "R5 stack narrow", core_sp_val, 64'hFFFF_FFFF_C000_0000);

    // R4 launch core 2
    access(1'b1, 1'b1, 4'h2, 64'd2, 2'd0);
    chk(core_pc_load == 4'b0100, "R4 pc strobe", 64'(core_pc_load), 64'h4);
    chk(core_sp_load == 4'b0100, "R4 sp strobe", 64'(core_sp_load), 64'h4);
    chk(core_run == 4'b0101, "R4 run", 64'(core_run), 64'h5);
    chk(core_pc_val == 64'h9000_0000, "R4 pc value", core_pc_val, 64'h9000_0000);
    idle();
    chk(core_pc_load == 0 && core_sp_load == 0, "R4 strobe one cycle", 64'(core_pc_load), 64'h0);
    access(1'b1, 1'b1, 4'h2, 64'd7, 2'd0);
    chk(core_pc_load == 0 && core_run == 4'b0101, "R4 out of range",
        {56'd0, core_pc_load, core_run}, 64'h05);

    // R7 resume
    access(1'b1, 1'b1, 4'h6, 64'd3, 2'd0);
    chk(core_run == 4'b1101, "R7 resume 3", 64'(core_run), 64'hD);
    access(1'b1, 1'b1, 4'h6, 64'd9, 2'd0);
    chk(core_run == 4'b1101, "R7 out of range", 64'(core_run), 64'hD);

    // R6 halt others
    access(1'b1, 1'b1, 4'h5, 64'd2, 2'd0);
    chk(core_run == 4'b0100, "R6 keep running", 64'(core_run), 64'h4);
    access(1'b1, 1'b1, 4'h5, 64'd1, 2'd0);
    chk(core_run == 4'b0000, "R6 keep stopped", 64'(core_run), 64'h0);
    access(1'b1, 1'b1, 4'h6, 64'd1, 2'd0);
    chk(core_run == 4'b0010, "R7 resume 1", 64'(core_run), 64'h2);
    access(1'b1, 1'b1, 4'h5, 64'd9, 2'd0);
    chk(core_run == 4'b0000, "R6 out of range", 64'(core_run), 64'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule